// File: doc/BRIEF.md
# Addressable Cascadable Delay Line

This block is a serial delay line for one-bit data. It is built from units of sixteen storage stages each. A stage moves its bit to the next stage only on a rising clock edge while the shift enable is high. A run-time tap address picks which stage feeds the tap output, so the delay can be changed without touching the contents.

Each unit also drives a cascade bit taken from its final stage. That bit feeds the serial input of the next unit, so a parameter sets how many units form one long line. The low four address bits go to every unit and pick a stage inside it. The remaining upper bits pick which unit's tap reaches the output.

The block has no reset input. All stored bits start at zero after power-up. Typical uses are balancing pipeline paths and building a programmable delay.

Top module: `tapped_delay_chain`

## Requirements
- R1: One unit stores exactly 16 stages. With the address in the range 0 to 15, the tap output shows the serial input as it was 1 to 16 enabled clock edges earlier.
- R2: When the shift enable is low at a rising edge, no stored bit changes. The tap output, for an unchanged address, and the cascade output both keep their values.
- R3: The tap delay equals the address plus one enabled edge across the whole chain. Address bits [3:0] pick the stage inside a unit, and the upper bits pick the unit, with unit 0 nearest the input. The longest delay is UNITS*16 edges.
- R4: The tap output follows a change of address with no clock edge in between.
- R5: The cascade output always carries the last stage of the last unit. It equals the tap output when the address is UNITS*16-1.
- R6: Every stored bit is zero after power-up, so every tap address and the cascade output read 0 until data is shifted in.
- R7: Every clock edge with the enable high moves each stage by exactly one place, with stage 0 loading the serial input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| shift_en | input | 1 | Shift enable; the contents hold while it is low |
| din | input | 1 | Serial data into stage 0 of unit 0 |
| tap_sel | input | ADDR_W (7 by default) | Tap address: upper bits pick the unit, [3:0] pick the stage |
| tap_out | output | 1 | Bit held in the addressed stage, combinational in the address |
| chain_out | output | 1 | Last stage of the last unit |

## Verification
Data shifted in at an enabled edge appears on the tap output after the address plus one enabled edges. A change of address shows on the tap output in the same cycle, with no edge needed. The bench drives its inputs on the falling edge and samples one time unit after the rising edge. It compares each sample with a bit-history model that shifts only on enabled edges, so the expected delay comes from the model's index and not from a cycle count. Address sweeps without a shifting edge cover R4 and R6: the enable is held low, and each address is sampled one time unit after it is set.

// File: rtl/delay_chain_pkg.sv
package delay_chain_pkg;
    // Stages held by one unit and width of the in-unit tap address
    localparam int UNIT_STAGES = 16;
    localparam int UNIT_SEL_W  = $clog2(UNIT_STAGES);

    // Width of the unit index; kept at least one bit wide
    function automatic int unit_idx_width(input int units);
        return (units > 1) ? $clog2(units) : 1;
    endfunction
endpackage

// File: rtl/delay_unit.sv
module delay_unit #(
    parameter int STAGES = delay_chain_pkg::UNIT_STAGES,
    localparam int SEL_W = $clog2(STAGES)
) (
    input  logic             clk,
    input  logic             shift_en,
    input  logic             ser_in,
    input  logic [SEL_W-1:0] stage_sel,
    output logic             stage_tap,
    output logic             stage_last
);
    // Storage starts cleared at power-up; no reset of the contents
    logic [STAGES-1:0] stage_q = '0;

    always_ff @(posedge clk) begin
        if (shift_en) begin
            stage_q <= {stage_q[STAGES-2:0], ser_in};
        end
    end

    assign stage_tap  = stage_q[stage_sel];
    assign stage_last = stage_q[STAGES-1];
endmodule

// File: rtl/unit_tap_mux.sv
module unit_tap_mux #(
    parameter int UNITS = 8,
    localparam int IDX_W = delay_chain_pkg::unit_idx_width(UNITS),
    localparam int SLOTS = 1 << IDX_W
) (
    input  logic [UNITS-1:0] unit_taps,
    input  logic [IDX_W-1:0] unit_idx,
    output logic             picked
);
    logic [SLOTS-1:0] padded;

    always_comb begin
        padded = '0;
        padded[UNITS-1:0] = unit_taps;
    end

    assign picked = padded[unit_idx];
endmodule

// File: rtl/tapped_delay_chain.sv
module tapped_delay_chain #(
    parameter int UNITS = 8,
    localparam int STAGES   = delay_chain_pkg::UNIT_STAGES,
    localparam int LOW_W    = delay_chain_pkg::UNIT_SEL_W,
    localparam int IDX_W    = delay_chain_pkg::unit_idx_width(UNITS),
    localparam int ADDR_W   = LOW_W + $clog2(UNITS)
) (
    input  logic              clk,
    input  logic              shift_en,
    input  logic              din,
    input  logic [ADDR_W-1:0] tap_sel,
    output logic              tap_out,
    output logic              chain_out
);
    logic [UNITS:0]     link;
    logic [UNITS-1:0]   unit_tap;
    logic [IDX_W-1:0]   unit_idx;
    logic [LOW_W-1:0]   stage_idx;

    assign link[0]   = din;
    assign stage_idx = tap_sel[LOW_W-1:0];

    generate
        if (UNITS > 1) begin : g_idx_multi
            assign unit_idx = tap_sel[ADDR_W-1:LOW_W];
        end else begin : g_idx_single
            assign unit_idx = '0;
        end

        for (genvar u = 0; u < UNITS; u++) begin : g_unit
            delay_unit #(.STAGES(STAGES)) unit_i (
                .clk        (clk),
                .shift_en   (shift_en),
                .ser_in     (link[u]),
                .stage_sel  (stage_idx),
                .stage_tap  (unit_tap[u]),
                .stage_last (link[u+1])
            );
        end
    endgenerate

    unit_tap_mux #(.UNITS(UNITS)) mux_i (
        .unit_taps (unit_tap),
        .unit_idx  (unit_idx),
        .picked    (tap_out)
    );

    assign chain_out = link[UNITS];
endmodule

// File: rtl/delay_chain_checker.sv
module delay_chain_checker #(
    parameter int UNITS = 8,
    localparam int ADDR_W = delay_chain_pkg::UNIT_SEL_W + $clog2(UNITS),
    localparam int LAST   = UNITS * delay_chain_pkg::UNIT_STAGES - 1
) (
    input logic              clk,
    input logic              shift_en,
    input logic              din,
    input logic [ADDR_W-1:0] tap_sel,
    input logic              tap_out,
    input logic              chain_out
);
    // Goes high after the first edge so that $past has a real history
    logic armed = 1'b0;
    always_ff @(posedge clk) armed <= 1'b1;

    // R7: stage 0 holds the input taken at the previous enabled edge
    p_first_stage_r7: assert property (@(posedge clk) disable iff (!armed)
        ($past(shift_en) && tap_sel == '0) |-> (tap_out == $past(din)));

    // R2: a disabled edge leaves the tap unchanged for a steady address
    p_hold_tap_r2: assert property (@(posedge clk) disable iff (!armed)
        (!$past(shift_en) && $stable(tap_sel)) |-> $stable(tap_out));

    // R2: a disabled edge leaves the cascade bit unchanged
    p_hold_cascade_r2: assert property (@(posedge clk) disable iff (!armed)
        !$past(shift_en) |-> $stable(chain_out));

    // R5: the top address reads the same stage as the cascade output
    p_last_tap_r5: assert property (@(posedge clk) disable iff (!armed)
        (tap_sel == ADDR_W'(LAST)) |-> (tap_out == chain_out));
endmodule

bind tapped_delay_chain delay_chain_checker #(.UNITS(UNITS)) chk_i (
    .clk       (clk),
    .shift_en  (shift_en),
    .din       (din),
    .tap_sel   (tap_sel),
    .tap_out   (tap_out),
    .chain_out (chain_out)
);

// File: tb/tapped_delay_chain_tb_top.sv
module tapped_delay_chain_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int UNITS      = 8;
    localparam int STAGES     = 16;
    localparam int TOTAL      = UNITS * STAGES;
    localparam int ADDR_W     = $clog2(TOTAL);

    logic              clk = 1'b0;
    logic              shift_en = 1'b0;
    logic              din = 1'b0;
    logic [ADDR_W-1:0] tap_sel = '0;
    logic              tap_out;
    logic              chain_out;

    logic [TOTAL-1:0]  model = '0;
    int                checks = 0;
    int                errors = 0;
    bit                done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tapped_delay_chain #(.UNITS(UNITS)) dut_i (
        .clk       (clk),
        .shift_en  (shift_en),
        .din       (din),
        .tap_sel   (tap_sel),
        .tap_out   (tap_out),
        .chain_out (chain_out)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b sel=%0d t=%0t",
                     req, what, act, exp, tap_sel, $time);
        end
    endtask

    // One cycle: drive at the falling edge, update the model at the rising edge, sample after it
    task automatic step(input string req, input logic en, input logic d, input logic [ADDR_W-1:0] s);
        @(negedge clk);
        shift_en = en;
        din      = d;
        tap_sel  = s;
        @(posedge clk);
        if (en) model = {model[TOTAL-2:0], d};
        #1;
        check(req, "tap", tap_out, model[s]);
        check("R5", "cascade", chain_out, model[TOTAL-1]);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R6: every address reads zero before anything is shifted in
        shift_en = 1'b0;
        for (int s = 0; s < TOTAL; s++) begin
            tap_sel = ADDR_W'(s);
            #1;
            check("R6", "tap", tap_out, 1'b0);
        end
        check("R6", "cascade", chain_out, 1'b0);

        // R1: each in-unit address with the enable held high
        for (int s = 0; s < STAGES; s++) begin
            for (int k = 0; k < 20; k++) step("R1", 1'b1, 1'($urandom), ADDR_W'(s));
        end

        // R2: disabled edges with changing data must not move anything
        for (int k = 0; k < 40; k++) step("R2", 1'b0, 1'($urandom), ADDR_W'($urandom % TOTAL));

        // R3 and R7: random enable, data and address over the full chain
        for (int k = 0; k < 1500; k++)
            step("R3", ($urandom % 4) != 0, 1'($urandom), ADDR_W'($urandom % TOTAL));

        // R4: address sweep between edges, enable low
        @(negedge clk);
        shift_en = 1'b0;
        for (int s = 0; s < TOTAL; s++) begin
            tap_sel = ADDR_W'(s);
            #1;
            check("R4", "tap", tap_out, model[s]);
        end

        // R5: full fill watched at the top address
        for (int k = 0; k < TOTAL + 8; k++) step("R5", 1'b1, 1'($urandom), ADDR_W'(TOTAL - 1));

        // R7: single marker walked through every stage
        for (int k = 0; k < TOTAL; k++) step("R7", 1'b1, 1'b0, ADDR_W'(k));
        step("R7", 1'b1, 1'b1, '0);
        for (int k = 1; k < TOTAL; k++) step("R7", 1'b1, 1'b0, ADDR_W'(k));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule